// File: doc/BRIEF.md
# Frame-Sync Pulsed Serial Master

This block is a synchronous serial master that opens each frame with a single serial-clock-period pulse on a frame-sync line instead of holding a chip select low. Words written into an 8-entry transmit queue are shifted out MSB first on a data-out line. The block samples a data-in line during the same serial clock periods and stores each received word in an 8-entry receive queue. The frame length can be set from 4 to 16 bits.

The serial clock comes from the system clock through an even divider. All logic runs in the system clock domain, using internal rise and fall strobes. Data is launched on serial clock rising edges, and both ends capture on falling edges. If another word is waiting when a frame reaches its last bit, the next frame-sync pulse overlaps that last bit. The next frame then follows with no idle period. When nothing is queued, the serial clock and frame-sync lines rest low and the data-out driver is switched off.

Top module: `fsSerialMaster`

## Requirements
- R1: While `busy` is low, `sclk` and `fsync` are low and `sdoOe` is 0. After reset, `busy` is 0, `txEmpty` is 1, `rxEmpty` is 1 and `rxOverrun` is 0.
- R2: A frame starts with a serial clock rising edge at which `fsync` goes high. `fsync` stays high for exactly one serial clock period, and the transmit queue head is popped at that edge.
- R3: Starting at the rising edge after the frame-sync period, the word is driven on `sdo` most significant bit first, one bit per serial period, with `sdoOe` at 1. The bits sent are bits [L-1:0] of the queued word, for a frame length L.
- R4: The frame length L equals `frameLen`, limited to the range 4..16: values below 4 give 4 and values above 16 give 16. L is captured when the frame's word is popped.
- R5: `sdi` is sampled on each serial clock falling edge of the data bits. The received word is written to the receive queue at the first rising-edge strobe after the last bit. The word is right-justified and its bits above L are zero.
- R6: If the transmit queue holds a word when the last data bit period of a frame begins, `fsync` rises at that same edge. The next frame's MSB then follows one serial period later, with no idle period.
- R7: One serial clock period lasts 2*D system clocks, where D = `clkDiv`; a `clkDiv` of 0 behaves as 1.
- R8: The transmit queue holds 8 words. `txFull` is high when 8 words are held, and a write while full is dropped.
- R9: If a received word arrives while the receive queue is full, the word is discarded and `rxOverrun` is set. `rxOverrun` stays set until reset. `rxData` shows the oldest word, and `rxRead` removes it.
- R10: `busy` rises with the first frame-sync pulse. It stays high across back-to-back frames and falls after the last frame once the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameLen | input | 5 | Frame length in bits (limited to 4..16) |
| clkDiv | input | 8 | Half serial period in system clocks |
| txData | input | 16 | Word to queue for sending |
| txWrite | input | 1 | Queue `txData` |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxData | output | 16 | Oldest received word |
| rxRead | input | 1 | Remove the oldest received word |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| rxOverrun | output | 1 | Sticky: a received word was lost |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame-sync pulse |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-entry queues and an 8-bit divider. It sweeps every frame length from 4 to 16 across divider settings 0 to 3, plus out-of-range lengths 2 and 20, with two back-to-back words at each setting. A bench slave answers each frame with a computed word, and all expected values follow arithmetically from the frame index and length. A slow divider setting allows the transmit queue to be overfilled before the first pop. A nine-frame run against an unread receive queue shows a word being discarded and the overrun flag being set.

// File: rtl/fssPkg.sv
package fssPkg;
  // Strobes from the control unit to the datapath, each valid for one system clock.
  typedef struct packed {
    logic load;    // pop transmit head into the shift register
    logic shift;   // present next bit on sdo
    logic sample;  // shift sdi into receive register
    logic commit;  // push received word
  } fssStrobe_t;

  localparam int FSS_MIN_LEN = 4;
endpackage

// File: rtl/fssFifo.sv
module fssFifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doWr, doRd;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: a write into a full queue with no read leaves it full, never wraps
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn && !rdEn) |=> full);
  // R9: reading an empty queue leaves it empty
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && !wrEn) |=> empty);
endmodule

// File: rtl/fssCtrl.sv
module fssCtrl
  import fssPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             txEmpty,
  output fssStrobe_t       strb,
  output logic [LEN_W-1:0] loadLen,
  output logic [LEN_W-1:0] curLen,
  output logic             sclk,
  output logic             fsync,
  output logic             sdoOe,
  output logic             busy
);
  logic [DIV_W-1:0] halfDiv, divCnt;
  logic             phase, divEn, tick, riseEv, fallEv;
  logic             active, b2bPend;
  logic [LEN_W-1:0] cyc, pendLen;
  logic             lastCyc, startIdle, goIdle, loadNext;

  // Clamp the requested length into the legal range.
  always_comb begin
    if (frameLen < LEN_W'(FSS_MIN_LEN))  loadLen = LEN_W'(FSS_MIN_LEN);
    else if (frameLen > LEN_W'(DATA_W))  loadLen = LEN_W'(DATA_W);
    else                                 loadLen = frameLen;
  end

  assign halfDiv = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
  assign divEn   = active || !txEmpty;
  assign tick    = divEn && (divCnt == halfDiv - DIV_W'(1));
  assign riseEv  = tick && !phase;
  assign fallEv  = tick && phase;

  assign lastCyc   = active && (cyc == curLen);
  assign startIdle = riseEv && !active && !txEmpty;
  assign goIdle    = riseEv && lastCyc && !b2bPend;
  assign loadNext  = riseEv && active && !lastCyc &&
                     ((cyc + LEN_W'(1)) == curLen) && !txEmpty;

  always_comb begin
    strb.load   = startIdle || loadNext;
    strb.shift  = riseEv && active && !goIdle;
    strb.sample = fallEv && active && (cyc != '0);
    strb.commit = riseEv && lastCyc;
  end

  // Rise/fall strobe generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (!divEn || goIdle) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      phase  <= !phase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      cyc     <= '0;
      curLen  <= LEN_W'(FSS_MIN_LEN);
      pendLen <= LEN_W'(FSS_MIN_LEN);
      b2bPend <= 1'b0;
      fsync   <= 1'b0;
      sclk    <= 1'b0;
      sdoOe   <= 1'b0;
    end else if (startIdle) begin
      active <= 1'b1;
      cyc    <= '0;
      curLen <= loadLen;
      fsync  <= 1'b1;
      sclk   <= 1'b1;
      sdoOe  <= 1'b0;
    end else if (riseEv && active) begin
      if (lastCyc) begin
        if (b2bPend) begin
          cyc     <= LEN_W'(1);
          curLen  <= pendLen;
          b2bPend <= 1'b0;
          fsync   <= 1'b0;
          sclk    <= 1'b1;
          sdoOe   <= 1'b1;
        end else begin
          active <= 1'b0;
          cyc    <= '0;
          fsync  <= 1'b0;
          sclk   <= 1'b0;
          sdoOe  <= 1'b0;
        end
      end else begin
        cyc   <= cyc + 1'b1;
        sclk  <= 1'b1;
        sdoOe <= 1'b1;
        fsync <= loadNext;
        if (loadNext) begin
          b2bPend <= 1'b1;
          pendLen <= loadLen;
        end
      end
    end else if (fallEv) begin
      sclk <= 1'b0;
    end
  end

  assign busy = active;

  // R1: idle lines quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclk && !fsync && !sdoOe));
  // R2: frame-sync never spans two rising strobes
  a_r2_fs_single: assert property (@(posedge clk) disable iff (!rstN)
    (riseEv && fsync) |=> !fsync);
  // R10: frame-sync only while busy
  a_r10_fs_busy: assert property (@(posedge clk) disable iff (!rstN)
    fsync |-> busy);
  // R6: a pending follow-on frame keeps the transfer running
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && b2bPend) |=> (busy && sclk));
endmodule

// File: rtl/fssDatapath.sv
module fssDatapath
  import fssPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              txFull,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxRead,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              rxOverrun,
  input  fssStrobe_t        strb,
  input  logic [LEN_W-1:0]  loadLen,
  input  logic [LEN_W-1:0]  curLen,
  input  logic              sdi,
  output logic              sdo
);
  logic [DATA_W-1:0] txHead, aligned, shiftReg, rxShift, pushData;
  logic [DATA_W-1:0] allOnes;
  logic [LEN_W-1:0]  alignSh;
  logic              rxWr;

  fssFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .wrEn(txWrite), .wrData(txData),
    .rdEn(strb.load), .rdData(txHead), .full(txFull), .empty(txEmpty));

  fssFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .wrEn(rxWr), .wrData(pushData),
    .rdEn(rxRead), .rdData(rxData), .full(rxFull), .empty(rxEmpty));

  // Left-justify the frame so its MSB sits at the top of the shift register.
  assign alignSh  = LEN_W'(DATA_W) - loadLen;
  assign aligned  = txHead << alignSh;
  assign allOnes  = '1;
  assign pushData = rxShift & ~(allOnes << curLen);
  assign rxWr     = strb.commit && !rxFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
    end else begin
      if (strb.shift) sdo <= shiftReg[DATA_W-1];
      if (strb.load)       shiftReg <= aligned;
      else if (strb.shift) shiftReg <= shiftReg << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (strb.sample) rxShift <= {rxShift[DATA_W-2:0], sdi};
      if (strb.commit && rxFull) rxOverrun <= 1'b1;
    end
  end

  // R2: a pop is only requested when the transmit queue has a word
  a_r2_pop_has_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !txEmpty);
  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);
  // R9: a word arriving at a full queue without a read leaves it full and flags it
  a_r9_drop_full: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && rxFull && !rxRead) |=> (rxFull && rxOverrun));
endmodule

// File: rtl/fsSerialMaster.sv
module fsSerialMaster
  import fssPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  localparam int LEN_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              txFull,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxRead,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              rxOverrun,
  output logic              sclk,
  output logic              fsync,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              sdi,
  output logic              busy
);
  fssStrobe_t       strb;
  logic [LEN_W-1:0] loadLen, curLen;

  fssCtrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .clkDiv(clkDiv),
    .txEmpty(txEmpty), .strb(strb), .loadLen(loadLen), .curLen(curLen),
    .sclk(sclk), .fsync(fsync), .sdoOe(sdoOe), .busy(busy));

  fssDatapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) i_data (
    .clk(clk), .rstN(rstN), .txData(txData), .txWrite(txWrite),
    .txFull(txFull), .txEmpty(txEmpty), .rxData(rxData), .rxRead(rxRead),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .rxOverrun(rxOverrun),
    .strb(strb), .loadLen(loadLen), .curLen(curLen), .sdi(sdi), .sdo(sdo));
endmodule

// File: tb/test_fsSerialMaster.sv
module test_fsSerialMaster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  frameLen = 5'd8;
  logic [7:0]  clkDiv = 8'd1;
  logic [15:0] txData = '0;
  logic        txWrite = 1'b0;
  logic        rxRead = 1'b0;
  logic        sdi = 1'b0;
  logic        txFull, txEmpty, rxFull, rxEmpty, rxOverrun;
  logic        sclk, fsync, sdo, sdoOe, busy;
  logic [15:0] rxData;

  fsSerialMaster i_fsSerialMaster (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .clkDiv(clkDiv),
    .txData(txData), .txWrite(txWrite), .txFull(txFull), .txEmpty(txEmpty),
    .rxData(rxData), .rxRead(rxRead), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxOverrun(rxOverrun), .sclk(sclk), .fsync(fsync), .sdo(sdo),
    .sdoOe(sdoOe), .sdi(sdi), .busy(busy));

  always #10 clk = !clk;  // 50 MHz

  int nChecks = 0, nFail = 0;
  int tbLen = 8, tbDiv = 1;
  logic [15:0] txExp [0:255];
  int txHead = 0, txTail = 0, wIdx = 0;
  logic [15:0] rxExp [0:255];
  int rxHead = 0, rxTail = 0, rxCnt = 0;
  logic expOverrun = 1'b0;
  int frameNo = 0, b2bCnt = 0;
  int cycNow = 0, lastRise = -1;
  logic prevSclk = 1'b0, fsLastRise = 1'b0, inFrame = 1'b0;
  int bitIdx = 0;
  logic [15:0] cap = '0, slvWord = '0;
  logic monOn = 1'b0;

  function automatic logic [15:0] lenMask(int len);
    return 16'((32'd1 << len) - 1);
  endfunction
  function automatic logic [15:0] slvPat(int n);
    return 16'((n * 937 + 453) ^ 16'hA5A5);
  endfunction
  function automatic logic [15:0] mstPat(int n);
    return 16'(n * 697 + 109);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench slave and protocol monitor
  always @(negedge clk) begin
    cycNow++;
    if (monOn) begin
      if (!busy) lastRise = -1;
      if (!prevSclk && sclk) begin
        if (lastRise >= 0) chk((cycNow - lastRise) == 2 * tbDiv, "R7 serial period", cycNow - lastRise, 2 * tbDiv);
        lastRise = cycNow;
        if (fsLastRise) begin
          inFrame = 1'b1; bitIdx = 0; cap = '0; slvWord = slvPat(frameNo);
        end else if (inFrame) bitIdx++;
        if (fsync) begin
          chk(!fsLastRise, "R2 fsync single period", 1, 0);
          chk(busy, "R10 busy during fsync", busy, 1);
          if (inFrame) begin
            chk(bitIdx == tbLen - 1, "R6 fsync in last bit", bitIdx, tbLen - 1);
            b2bCnt++;
          end
        end
        sdi = inFrame ? slvWord[tbLen - 1 - bitIdx] : 1'b0;
        fsLastRise = fsync;
      end
      if (prevSclk && !sclk && inFrame) begin
        chk(sdoOe, "R3 sdoOe in data bit", sdoOe, 1);
        cap = {cap[14:0], sdo};
        if (bitIdx == tbLen - 1) begin
          chk(cap == (txExp[txHead] & lenMask(tbLen)), "R3 R4 frame data", cap, txExp[txHead] & lenMask(tbLen));
          txHead++;
          if (rxCnt < 8) begin
            rxExp[rxTail] = slvWord & lenMask(tbLen); rxTail++; rxCnt++;
          end else expOverrun = 1'b1;
          frameNo++;
          inFrame = 1'b0;
        end
      end
    end
    prevSclk = sclk;
  end

  task automatic pushTx(input bit accept);
    @(negedge clk);
    txData = mstPat(wIdx); txWrite = 1'b1;
    if (accept) begin txExp[txTail] = mstPat(wIdx); txTail++; end
    wIdx++;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk);
    chk(!rxEmpty, "R9 rx word present", rxEmpty, 0);
    chk(rxData == rxExp[rxHead], "R5 received word", rxData, rxExp[rxHead]);
    rxHead++; rxCnt--;
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (busy || !txEmpty) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic runCfg(input int div, input int lenIn, input int effLen, input int nWr);
    int nAcc, f0;
    nAcc = (nWr > 8) ? 8 : nWr;
    @(negedge clk);
    clkDiv = 8'(div); frameLen = 5'(lenIn);
    tbLen = effLen; tbDiv = (div == 0) ? 1 : div;
    b2bCnt = 0; f0 = frameNo;
    for (int i = 0; i < nWr; i++) pushTx(i < 8);
    if (nWr > 8) chk(txFull, "R8 tx queue full", txFull, 1);
    waitIdle();
    chk(!sclk && !fsync && !sdoOe && !busy, "R1 idle lines", {sclk, fsync, sdoOe, busy}, 0);
    chk(frameNo - f0 == nAcc, "R8 frames sent", frameNo - f0, nAcc);
    chk(b2bCnt == nAcc - 1, "R6 back-to-back count", b2bCnt, nAcc - 1);
    for (int i = 0; i < nAcc; i++) readRx();
    chk(rxEmpty, "R9 rx drained", rxEmpty, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!sclk && !fsync && !sdoOe && !busy && txEmpty && rxEmpty && !rxOverrun,
        "R1 reset state", {sclk, fsync, sdoOe, busy, txEmpty, rxEmpty, rxOverrun}, 7'b0000110);
    monOn = 1'b1;
    for (int d = 0; d < 4; d++)
      for (int l = 4; l <= 16; l++) runCfg(d, l, l, 2);
    runCfg(1, 2, 4, 2);    // R4 clamp low
    runCfg(2, 20, 16, 2);  // R4 clamp high
    runCfg(20, 8, 8, 10);  // R8 overfill before the first pop
    chk(!rxOverrun, "R9 no spurious overrun", rxOverrun, 0);
    // R9 overrun: nine frames into an unread receive queue
    @(negedge clk);
    clkDiv = 8'd1; frameLen = 5'd4; tbLen = 4; tbDiv = 1;
    for (int i = 0; i < 8; i++) pushTx(1'b1);
    waitIdle();
    chk(rxFull && !rxOverrun, "R9 full without overrun", {rxFull, rxOverrun}, 2'b10);
    pushTx(1'b1);
    waitIdle();
    chk(rxFull, "R9 still full", rxFull, 1);
    chk(rxOverrun == expOverrun && rxOverrun, "R9 overrun set", rxOverrun, 1);
    for (int i = 0; i < 8; i++) readRx();
    chk(rxEmpty && rxOverrun, "R9 overrun sticky after drain", {rxEmpty, rxOverrun}, 2'b11);
    chk(!busy && txEmpty, "R10 busy low when done", busy, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule